// File: doc/BRIEF.md
# Sector Burst Data Mover

This block moves data between a storage controller and two user FIFOs in fixed bursts. A write transfer pulls data words from a user transmit FIFO and presents them to the controller. A read transfer drains an internal data buffer into a user receive FIFO. A burst is always 16 beats of 256 bits, which is 512 bytes, or one sector. A transfer is started with a single-cycle request that carries a direction and a length in sectors. The block runs one burst per sector and then pulses a completion flag.

The block does not throttle on per-beat empty or full flags. It decides once, before each burst, whether a whole burst can go. On the write side it checks that the transmit FIFO read count shows at least 16 stored words. On the read side it checks two things: the receive FIFO write count must still leave room for a burst, and the internal buffer must hold at least 16 words. A user FIFO with a narrower count port pads the unused upper count bits: the receive count with ones, the transmit count with zeros. With that padding the gate leans toward waiting, never toward overrun.

Both FIFO ports return read data one cycle after the enable. The block therefore issues each read one cycle ahead of the beat it feeds, so that the 16 outgoing beats form an unbroken run.

Top module: `fifo_burst_mover`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `tx_rd_en`, `buf_rd_en`, `wr_out_valid` and `rx_wr_en` are all 0.
- R2: A write burst begins only if, in the cycle before the first read enable, `tx_cnt` is at least 16, which means bits [15:4] are nonzero.
- R3: During a write burst `tx_rd_en` is high for exactly 16 consecutive cycles. Each word appears on `wr_out_data` with `wr_out_valid` high one cycle after its enable, in FIFO order.
- R4: `tx_empty` has no effect. A write transfer with `tx_empty` held at 1 moves the same number of beats, with the same timing.
- R5: A read burst begins only if, in the cycle before the first buffer read, `rx_cnt` bits [15:5] are not all ones (`rx_cnt` < 0xFFE0) and `buf_level` is at least 16.
- R6: During a read burst `buf_rd_en` is high for 16 consecutive cycles. `rx_wr_en` is high for 16 consecutive cycles, one cycle later, and carries each buffer word in order.
- R7: A transfer of N sectors produces exactly N bursts. `done` is high for one cycle, in the cycle that presents the last data beat. `busy` is low in the next cycle.
- R8: A start with `len` = 0 produces no enable. `done` goes high in the cycle after the start.
- R9: A `start` that arrives while `busy` is high is ignored. The running transfer keeps its direction and its length.
- R10: `dir` = 0 selects the write side and `dir` = 1 the read side. Only the selected side's enables are ever asserted during a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Single-cycle transfer request, taken only when idle |
| dir | input | 1 | 0 = transmit FIFO to controller, 1 = buffer to receive FIFO |
| len | input | 32 | Transfer length in 512-byte sectors |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| tx_cnt | input | 16 | Transmit FIFO stored-word count (pad unused upper bits with 0) |
| tx_empty | input | 1 | Transmit FIFO empty flag, ignored |
| tx_rd_en | output | 1 | Transmit FIFO read enable |
| tx_rd_data | input | 256 | Transmit FIFO data, valid one cycle after read enable |
| wr_out_valid | output | 1 | Write beat valid toward controller |
| wr_out_data | output | 256 | Write beat data toward controller |
| buf_level | input | 16 | Words held in the internal buffer |
| buf_rd_en | output | 1 | Internal buffer read enable |
| buf_rd_data | input | 256 | Internal buffer data, valid one cycle after read enable |
| rx_cnt | input | 16 | Receive FIFO write count (pad unused upper bits with 1) |
| rx_wr_en | output | 1 | Receive FIFO write enable |
| rx_wr_data | output | 256 | Receive FIFO write data |

## Verification
Transfers are run in both directions with lengths of 1 to 4 sectors. Counts sitting just past each gate threshold (16, 0xFFDF) separate a correct gate from an off-by-one gate, and saturated counts (0xFFFF) separate it from a gate that compares the wrong bits.

A write transfer with the empty flag held high shows that the flag plays no part. Held-off runs show that nothing moves until the gate opens: a transmit count of 15, a receive count of 0xFFE0, and a buffer level of 15.

Beat-order checks on both sides catch a misplaced pipeline stage. A start pulse in the middle of a transfer shows that the running transfer keeps its direction and length.

// File: rtl/fbm_pkg.sv
package fbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GATE = 2'd1,
        ST_RUN  = 2'd2,
        ST_FIN  = 2'd3
    } mover_st_e;

    typedef enum logic {
        SIDE_TX = 1'b0,
        SIDE_RX = 1'b1
    } side_e;

    typedef struct packed {
        logic  en;
        logic  done;
        logic  busy;
        side_e side;
    } mover_ctrl_t;

    function automatic int beat_bits(input int beats);
        return (beats > 1) ? $clog2(beats) : 1;
    endfunction

endpackage

// File: rtl/fbm_gate.sv
module fbm_gate
    import fbm_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LVL_W = 16,
    parameter int BURST = 16
) (
    input  side_e              side,
    input  logic [CNT_W-1:0]   tx_cnt,
    input  logic [CNT_W-1:0]   rx_cnt,
    input  logic [LVL_W-1:0]   buf_level,
    output logic               go
);
    localparam int RD_SHIFT = beat_bits(BURST) + 1;
    localparam logic [CNT_W-1:0] TX_MIN   = CNT_W'(BURST);
    localparam logic [CNT_W-1:0] RX_BLOCK = {{(CNT_W-RD_SHIFT){1'b1}}, {RD_SHIFT{1'b0}}};
    localparam logic [LVL_W-1:0] BUF_MIN  = LVL_W'(BURST);

    logic tx_ok, rx_ok;

    // at least one full burst stored in the transmit FIFO
    assign tx_ok = (tx_cnt >= TX_MIN);
    // receive count below the all-ones upper field and a burst buffered
    assign rx_ok = (rx_cnt < RX_BLOCK) && (buf_level >= BUF_MIN);

    always_comb begin
        if (side == SIDE_TX) go = tx_ok;
        else                 go = rx_ok;
    end

endmodule

// File: rtl/fbm_seq.sv
module fbm_seq
    import fbm_pkg::*;
#(
    parameter int BURST = 16,
    parameter int LEN_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  side_e             side_in,
    input  logic [LEN_W-1:0]  len,
    input  logic              go,
    output mover_ctrl_t       ctrl
);
    localparam int BEAT_W = beat_bits(BURST);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST - 1);

    mover_st_e         st;
    logic [BEAT_W-1:0] beat;
    logic [LEN_W-1:0]  sec;
    logic [LEN_W-1:0]  len_q;
    side_e             side_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            beat   <= '0;
            sec    <= '0;
            len_q  <= '0;
            side_q <= SIDE_TX;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    side_q <= side_in;
                    len_q  <= len;
                    sec    <= '0;
                    st     <= (len == '0) ? ST_FIN : ST_GATE;
                end
                ST_GATE: if (go) begin
                    beat <= '0;
                    st   <= ST_RUN;
                end
                ST_RUN: begin
                    beat <= beat + BEAT_W'(1);
                    if (beat == LAST_BEAT) begin
                        sec <= sec + LEN_W'(1);
                        st  <= (sec + LEN_W'(1) == len_q) ? ST_FIN : ST_GATE;
                    end
                end
                ST_FIN: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign ctrl.en   = (st == ST_RUN);
    assign ctrl.done = (st == ST_FIN);
    assign ctrl.busy = (st != ST_IDLE);
    assign ctrl.side = side_q;

    AST_RUN_UNBROKEN: assert property (@(posedge clk) disable iff (rst)
        (ctrl.en && beat != LAST_BEAT) |=> ctrl.en); // R3
    AST_HOLD_WITHOUT_GO: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GATE && !go) |=> !ctrl.en); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ctrl.done |=> (!ctrl.done && !ctrl.busy)); // R7
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.busy && start && len == '0) |=> ctrl.done); // R8
    AST_SIDE_KEPT: assert property (@(posedge clk) disable iff (rst)
        (ctrl.busy && !ctrl.done && $past(ctrl.busy)) |-> $stable(ctrl.side)); // R9

endmodule

// File: rtl/fbm_pipe.sv
module fbm_pipe #(
    parameter int DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] rd_data,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);
    // source data arrives one cycle after its enable; mark that cycle valid
    always_ff @(posedge clk) begin
        if (rst) out_vld <= 1'b0;
        else     out_vld <= rd_en;
    end

    assign out_data = rd_data;

endmodule

// File: rtl/fifo_burst_mover.sv
module fifo_burst_mover
    import fbm_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int CNT_W  = 16,
    parameter int LVL_W  = 16,
    parameter int LEN_W  = 32,
    parameter int BURST  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir,
    input  logic [LEN_W-1:0]  len,
    output logic              busy,
    output logic              done,
    input  logic [CNT_W-1:0]  tx_cnt,
    input  logic              tx_empty,
    output logic              tx_rd_en,
    input  logic [DATA_W-1:0] tx_rd_data,
    output logic              wr_out_valid,
    output logic [DATA_W-1:0] wr_out_data,
    input  logic [LVL_W-1:0]  buf_level,
    output logic              buf_rd_en,
    input  logic [DATA_W-1:0] buf_rd_data,
    input  logic [CNT_W-1:0]  rx_cnt,
    output logic              rx_wr_en,
    output logic [DATA_W-1:0] rx_wr_data
);
    localparam int TX_SHIFT = beat_bits(BURST);
    localparam int RX_SHIFT = TX_SHIFT + 1;

    mover_ctrl_t ctrl;
    logic        go;
    side_e       side_in;

    assign side_in = side_e'(dir);

    fbm_gate #(.CNT_W(CNT_W), .LVL_W(LVL_W), .BURST(BURST)) u_gate (
        .side      (ctrl.side),
        .tx_cnt    (tx_cnt),
        .rx_cnt    (rx_cnt),
        .buf_level (buf_level),
        .go        (go)
    );

    fbm_seq #(.BURST(BURST), .LEN_W(LEN_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .side_in (side_in),
        .len     (len),
        .go      (go),
        .ctrl    (ctrl)
    );

    assign tx_rd_en  = ctrl.en && (ctrl.side == SIDE_TX);
    assign buf_rd_en = ctrl.en && (ctrl.side == SIDE_RX);
    assign busy      = ctrl.busy;
    assign done      = ctrl.done;

    fbm_pipe #(.DATA_W(DATA_W)) u_tx_pipe (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (tx_rd_en),
        .rd_data  (tx_rd_data),
        .out_vld  (wr_out_valid),
        .out_data (wr_out_data)
    );

    fbm_pipe #(.DATA_W(DATA_W)) u_rx_pipe (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (buf_rd_en),
        .rd_data  (buf_rd_data),
        .out_vld  (rx_wr_en),
        .out_data (rx_wr_data)
    );

    AST_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
        !(tx_rd_en && buf_rd_en)); // R10
    AST_RX_GATE: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && !tx_rd_en && !buf_rd_en && (&rx_cnt[CNT_W-1:RX_SHIFT]))
        |=> !buf_rd_en); // R5
    AST_TX_GATE: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && !tx_rd_en && !buf_rd_en && !(|tx_cnt[CNT_W-1:TX_SHIFT]))
        |=> !tx_rd_en); // R2
    AST_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && !tx_rd_en && !buf_rd_en && ctrl.side == SIDE_TX
         && tx_empty && (|tx_cnt[CNT_W-1:TX_SHIFT])) |=> tx_rd_en); // R4
    AST_RX_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        rx_wr_en |-> $past(buf_rd_en)); // R6

endmodule

// File: tb/sim_fifo_burst_mover.sv
`timescale 1ns/1ps
module sim_fifo_burst_mover;

    typedef struct packed {
        logic        d;
        logic        emp;
        logic [7:0]  n;
        logic [15:0] tc;
        logic [15:0] rc;
        logic [15:0] lv;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t TBL [NVEC] = '{
        '{d:1'b0, emp:1'b0, n:8'd1, tc:16'h0010, rc:16'hFFFF, lv:16'h0000}, // R2 R3 threshold
        '{d:1'b0, emp:1'b0, n:8'd3, tc:16'hFFFF, rc:16'h0000, lv:16'hFFFF}, // R3 R7 saturated count
        '{d:1'b1, emp:1'b0, n:8'd1, tc:16'h0000, rc:16'h0000, lv:16'h0010}, // R5 R6 level threshold
        '{d:1'b1, emp:1'b0, n:8'd4, tc:16'hFFFF, rc:16'hFFDF, lv:16'hFFFF}, // R5 R7 count threshold
        '{d:1'b0, emp:1'b1, n:8'd2, tc:16'h0020, rc:16'h0000, lv:16'h0000}, // R4 empty held
        '{d:1'b1, emp:1'b1, n:8'd2, tc:16'h0000, rc:16'h07FF, lv:16'h0064}  // R10 read side
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         dir = 1'b0;
    logic [31:0]  len = '0;
    logic         busy, done;
    logic [15:0]  tx_cnt = '0;
    logic         tx_empty = 1'b0;
    logic         tx_rd_en;
    logic [255:0] tx_rd_data = '0;
    logic         wr_out_valid;
    logic [255:0] wr_out_data;
    logic [15:0]  buf_level = '0;
    logic         buf_rd_en;
    logic [255:0] buf_rd_data = '0;
    logic [15:0]  rx_cnt = '0;
    logic         rx_wr_en;
    logic [255:0] rx_wr_data;

    int n_chk = 0, n_fail = 0;
    int n_txen = 0, n_bufen = 0, n_wrv = 0, n_rxv = 0;
    int tx_word = 0, buf_word = 0, exp_wr = 0, exp_rx = 0;
    int run_tx = 0, run_buf = 0, run_rx = 0;
    logic        prev_txen = 1'b0, prev_bufen = 1'b0;
    logic [15:0] prev_tc = '0, prev_rc = '0, prev_lv = '0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fifo_burst_mover u0 (
        .clk(clk), .rst(rst), .start(start), .dir(dir), .len(len),
        .busy(busy), .done(done),
        .tx_cnt(tx_cnt), .tx_empty(tx_empty), .tx_rd_en(tx_rd_en), .tx_rd_data(tx_rd_data),
        .wr_out_valid(wr_out_valid), .wr_out_data(wr_out_data),
        .buf_level(buf_level), .buf_rd_en(buf_rd_en), .buf_rd_data(buf_rd_data),
        .rx_cnt(rx_cnt), .rx_wr_en(rx_wr_en), .rx_wr_data(rx_wr_data)
    );

    // FIFO models: data valid one cycle after enable
    always @(posedge clk) begin
        if (tx_rd_en) begin
            tx_rd_data <= {224'd0, 32'(tx_word)};
            tx_word    <= tx_word + 1;
        end
        if (buf_rd_en) begin
            buf_rd_data <= {224'd0, 32'(32'h1000_0000 + buf_word)};
            buf_word    <= buf_word + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_rd_en) n_txen++;
            if (buf_rd_en) n_bufen++;
            if (tx_rd_en && !prev_txen) chk(prev_tc >= 16'd16, "R2", prev_tc, 16);
            if (buf_rd_en && !prev_bufen)
                chk(prev_rc < 16'hFFE0 && prev_lv >= 16'd16, "R5", prev_rc, prev_lv);
            if (wr_out_valid) begin
                n_wrv++;
                chk(wr_out_data[31:0] == 32'(exp_wr), "R3", wr_out_data[31:0], exp_wr);
                exp_wr++;
            end
            if (rx_wr_en) begin
                n_rxv++;
                chk(rx_wr_data[31:0] == 32'(32'h1000_0000 + exp_rx), "R6",
                    rx_wr_data[31:0], 32'h1000_0000 + exp_rx);
                exp_rx++;
            end
            if (tx_rd_en) run_tx++;
            else if (run_tx != 0) begin chk(run_tx == 16, "R3", run_tx, 16); run_tx = 0; end
            if (buf_rd_en) run_buf++;
            else if (run_buf != 0) begin chk(run_buf == 16, "R6", run_buf, 16); run_buf = 0; end
            if (rx_wr_en) run_rx++;
            else if (run_rx != 0) begin chk(run_rx == 16, "R6", run_rx, 16); run_rx = 0; end
        end
        prev_txen  = tx_rd_en;
        prev_bufen = buf_rd_en;
        prev_tc    = tx_cnt;
        prev_rc    = rx_cnt;
        prev_lv    = buf_level;
    end

    task automatic start_only(input logic d, input logic emp, input int n,
                              input logic [15:0] tc, input logic [15:0] rc, input logic [15:0] lv);
        n_txen = 0; n_bufen = 0; n_wrv = 0; n_rxv = 0;
        dir = d; tx_empty = emp; len = 32'(n);
        tx_cnt = tc; rx_cnt = rc; buf_level = lv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(input logic d, input int n);
        int k = 0;
        while (!done && k < 5000) begin @(negedge clk); k++; end
        chk(done == 1'b1, "R7", done, 1);
        if (n > 0) chk((d ? rx_wr_en : wr_out_valid) == 1'b1, "R7", 0, 1);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R7", busy, 0);
    endtask

    task automatic check_counts(input logic d, input int n);
        chk((d ? n_bufen : n_txen) == 16 * n, "R7", d ? n_bufen : n_txen, 16 * n);
        chk((d ? n_rxv : n_wrv) == 16 * n, "R7", d ? n_rxv : n_wrv, 16 * n);
        chk((d ? n_txen : n_bufen) == 0, "R10", d ? n_txen : n_bufen, 0);
    endtask

    initial begin
        @(negedge clk);
        chk(!busy && !done && !tx_rd_en && !buf_rd_en, "R1", busy, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !done && !wr_out_valid && !rx_wr_en, "R1", busy, 0);
        @(negedge clk);
        chk(!busy && !tx_rd_en && !buf_rd_en, "R1", busy, 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            start_only(TBL[i].d, TBL[i].emp, int'(TBL[i].n), TBL[i].tc, TBL[i].rc, TBL[i].lv);
            wait_done(TBL[i].d, int'(TBL[i].n));
            check_counts(TBL[i].d, int'(TBL[i].n));
            if (TBL[i].emp && !TBL[i].d) chk(n_txen == 16 * int'(TBL[i].n), "R4", n_txen, 16 * TBL[i].n);
        end

        // R8: zero length
        start_only(1'b0, 1'b0, 0, 16'hFFFF, 16'h0, 16'hFFFF);
        chk(done == 1'b1, "R8", done, 1);
        @(negedge clk);
        chk(busy == 1'b0 && n_txen == 0 && n_bufen == 0, "R8", n_txen + n_bufen, 0);

        // R2: transmit count one short holds the transfer
        start_only(1'b0, 1'b0, 2, 16'h000F, 16'h0, 16'h0);
        repeat (20) @(negedge clk);
        chk(n_txen == 0 && busy == 1'b1, "R2", n_txen, 0);
        tx_cnt = 16'h0010;
        wait_done(1'b0, 2);
        check_counts(1'b0, 2);

        // R5: receive count at the all-ones field holds, then level one short holds
        start_only(1'b1, 1'b0, 1, 16'h0, 16'hFFE0, 16'hFFFF);
        repeat (20) @(negedge clk);
        chk(n_bufen == 0, "R5", n_bufen, 0);
        rx_cnt = 16'h0000; buf_level = 16'd15;
        repeat (20) @(negedge clk);
        chk(n_bufen == 0, "R5", n_bufen, 0);
        buf_level = 16'd16;
        wait_done(1'b1, 1);
        check_counts(1'b1, 1);

        // R9: start while busy is ignored
        start_only(1'b0, 1'b0, 2, 16'hFFFF, 16'h0, 16'hFFFF);
        repeat (5) @(negedge clk);
        dir = 1'b1; len = 32'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(1'b0, 2);
        chk(n_txen == 32 && n_bufen == 0, "R9", n_txen, 32);
        repeat (10) @(negedge clk);
        chk(busy == 1'b0 && n_bufen == 0, "R9", n_bufen, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            chk(1'b0, "watchdog", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule